// File: doc/BRIEF.md
# Quad Double-Buffered DAC Command Controller

This block turns complete 16-bit command words into register updates for a four-channel converter. Each channel has two registers. The staging register takes new data. The output register holds the code that the analog side converts. A command can write one staging register, copy every staging register into the output registers, or write all eight registers with one value.

The same decoder also controls three things around the channels. It can put the block into a low-power sleep state. A hardware permit input can refuse that sleep or end it. It sets a general-purpose logic output, and it chooses which clock edge a downstream echo shifter uses.

Words come from a serial front end that is not part of this block. That front end raises `word_valid_i` for one clock when all 16 bits have arrived. All outputs are registered and change on the clock edge that accepts the word. The asynchronous active-low reset is both the power-on reset and the external clear.

Top module: `quad_dac_cmd_ctrl`

## Requirements
- R1: After reset, all four output codes are 0, `shutdown_o`=0, `out_en_o`=1, `user_out_o`=0 and `echo_mode_o`=0.
- R2: The word is laid out as bits [15:14] address, [13:12] control, [11:2] data and [1:0] sub-bits. With control 01, the data is written to the staging register of channel `address` (0=A … 3=D), and no output code changes.
- R3: With control 11, the data is written to the addressed staging register. In the same cycle, all four output registers take their staging contents, including the newly written value.
- R4: Opcode 0100 (address,control) copies every staging register to its output register and clears `shutdown_o`.
- R5: Opcode 1000 writes the data field to all four staging and all four output registers, and clears `shutdown_o`.
- R6: Opcode 1100 sets `shutdown_o` and clears `out_en_o` only if `shdn_allow_i` is 1 in that cycle. Otherwise it has no effect.
- R7: Opcode 0010 sets `user_out_o` to 0, and opcode 0110 sets it to 1.
- R8: Opcode 1110 sets `echo_mode_o`=1 and opcode 1010 sets `echo_mode_o`=0. Both also copy all staging registers to the output registers.
- R9: Opcode 0000, or any word presented with `word_valid_i` low, leaves all outputs unchanged.
- R10: While in shutdown, `shdn_allow_i` low for a cycle clears `shutdown_o` on the next edge and restores `out_en_o`, with the codes exactly as they were before.
- R11: While in shutdown, writes to staging registers are kept but the output codes are held. A later transfer makes the kept values appear.
- R12: The two sub-bits never affect any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset and clear |
| word_valid_i | input | 1 | One-cycle strobe marking a complete command word |
| word_i | input | 16 | Command word |
| shdn_allow_i | input | 1 | High permits sleep; low blocks or ends it |
| dac_code_o | output | 40 | Output codes, channel A in bits [9:0] up to D in [39:30] |
| shutdown_o | output | 1 | Sleep state active |
| out_en_o | output | 1 | Analog output enable, low during sleep |
| user_out_o | output | 1 | General-purpose logic output |
| echo_mode_o | output | 1 | Echo edge select, 0 falling, 1 rising |

## Verification
The hardest case to reach is a staging write made during sleep that must stay invisible at the outputs and later reappear. The stimulus first enters sleep with the permit input high. It then writes a new value to one staging register and checks that the codes are unchanged. Next it drops the permit input to wake the block and checks that the old codes are still shown. Finally it re-enters sleep and issues a transfer, so the retained staging value must appear at the output. Permit-low refusal of sleep, and waking by a broadcast write, are driven in their own sequences.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CTL_W  = 2;
  localparam int DATA_W = 10;
  localparam int SUB_W  = 2;
  localparam int WORD_W = CH_W + CTL_W + DATA_W + SUB_W;
  localparam int OP_W   = CH_W + CTL_W;
  localparam int BANK_W = NUM_CH * DATA_W;

  typedef enum logic [CTL_W-1:0] {
    CTL_SYS      = 2'b00,
    CTL_LOAD     = 2'b01,
    CTL_AUX      = 2'b10,
    CTL_LOAD_XFR = 2'b11
  } ctl_e;

  typedef struct packed {
    logic              load_one;
    logic [CH_W-1:0]   ch;
    logic              load_all;
    logic              xfer_all;
    logic              wake;
    logic              sleep_req;
    logic              upo_set;
    logic              upo_val;
    logic              echo_set;
    logic              echo_val;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
  import qdac_pkg::*;
(
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o
);
  localparam int OP_LSB   = WORD_W - OP_W;
  localparam int DATA_LSB = SUB_W;

  logic [CH_W-1:0] addr;
  ctl_e            ctl;
  logic            unused_sub;

  assign addr       = word_i[WORD_W-1 -: CH_W];
  assign ctl        = ctl_e'(word_i[OP_LSB +: CTL_W]);
  assign unused_sub = ^word_i[SUB_W-1:0];

  always_comb begin
    cmd_o      = '0;
    cmd_o.ch   = addr;
    cmd_o.data = word_i[DATA_LSB +: DATA_W];
    if (valid_i) begin
      unique case (ctl)
        CTL_LOAD: cmd_o.load_one = 1'b1;
        CTL_LOAD_XFR: begin
          cmd_o.load_one = 1'b1;
          cmd_o.xfer_all = 1'b1;
          cmd_o.wake     = 1'b1;
        end
        CTL_AUX: begin
          unique case (addr)
            2'd0: begin cmd_o.upo_set = 1'b1; cmd_o.upo_val = 1'b0; end
            2'd1: begin cmd_o.upo_set = 1'b1; cmd_o.upo_val = 1'b1; end
            2'd2: begin
              cmd_o.echo_set = 1'b1; cmd_o.echo_val = 1'b0;
              cmd_o.xfer_all = 1'b1; cmd_o.wake     = 1'b1;
            end
            default: begin
              cmd_o.echo_set = 1'b1; cmd_o.echo_val = 1'b1;
              cmd_o.xfer_all = 1'b1; cmd_o.wake     = 1'b1;
            end
          endcase
        end
        default: begin
          unique case (addr)
            2'd0: ;  // no operation
            2'd1: begin cmd_o.xfer_all = 1'b1; cmd_o.wake = 1'b1; end
            2'd2: begin cmd_o.load_all = 1'b1; cmd_o.wake = 1'b1; end
            default: cmd_o.sleep_req = 1'b1;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  output logic [BANK_W-1:0] dac_code_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] stage_q, stage_d, out_q, out_d;
    logic              hit;

    assign hit = cmd_i.load_one && (cmd_i.ch == CH_W'(g));

    always_comb begin
      stage_d = stage_q;
      if (cmd_i.load_all || hit) stage_d = cmd_i.data;
    end

    // transfer sees the word written in the same cycle
    always_comb begin
      out_d = out_q;
      if (cmd_i.load_all)      out_d = cmd_i.data;
      else if (cmd_i.xfer_all) out_d = stage_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        out_q   <= '0;
      end else begin
        stage_q <= stage_d;
        out_q   <= out_d;
      end
    end

    assign dac_code_o[g*DATA_W +: DATA_W] = out_q;
  end
endmodule

// File: rtl/qdac_mode_ctrl.sv
module qdac_mode_ctrl
  import qdac_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t cmd_i,
  input  logic allow_i,
  output logic shutdown_o,
  output logic user_out_o,
  output logic echo_mode_o
);
  logic sd_q, sd_d;
  logic upo_q, echo_q;

  always_comb begin
    sd_d = sd_q;
    if (cmd_i.wake)                     sd_d = 1'b0;
    else if (cmd_i.sleep_req && allow_i) sd_d = 1'b1;
    else if (sd_q && !allow_i)          sd_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q   <= 1'b0;
      upo_q  <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      sd_q <= sd_d;
      if (cmd_i.upo_set)  upo_q  <= cmd_i.upo_val;
      if (cmd_i.echo_set) echo_q <= cmd_i.echo_val;
    end
  end

  assign shutdown_o  = sd_q;
  assign user_out_o  = upo_q;
  assign echo_mode_o = echo_q;
endmodule

// File: rtl/quad_dac_cmd_ctrl.sv
module quad_dac_cmd_ctrl
  import qdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shdn_allow_i,
  output logic [BANK_W-1:0] dac_code_o,
  output logic              shutdown_o,
  output logic              out_en_o,
  output logic              user_out_o,
  output logic              echo_mode_o
);
  cmd_t cmd;
  logic sd;

  qdac_cmd_decode i_decode (
    .valid_i (word_valid_i),
    .word_i  (word_i),
    .cmd_o   (cmd)
  );

  qdac_chan_bank i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .dac_code_o (dac_code_o)
  );

  qdac_mode_ctrl i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .allow_i     (shdn_allow_i),
    .shutdown_o  (sd),
    .user_out_o  (user_out_o),
    .echo_mode_o (echo_mode_o)
  );

  assign shutdown_o = sd;
  assign out_en_o   = ~sd;
endmodule

// File: rtl/quad_dac_cmd_ctrl_checker.sv
module quad_dac_cmd_ctrl_checker
  import qdac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic              shdn_allow_i,
  input logic [BANK_W-1:0] dac_code_o,
  input logic              shutdown_o,
  input logic              out_en_o,
  input logic              user_out_o,
  input logic              echo_mode_o
);
  assert_sleep_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> ($past(shdn_allow_i) && $past(word_valid_i) && $past(op_i) == 4'b1100));

  assert_hold_codes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && $past(shutdown_o)) |-> $stable(dac_code_o));

  assert_lockout_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shutdown_o) && !$past(shdn_allow_i)) |-> !shutdown_o);

  assert_wake_by_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shutdown_o) && $past(shdn_allow_i) && out_en_o) |-> $past(word_valid_i));

  assert_upo_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_out_o) |-> ($past(word_valid_i) && $past(op_i) == 4'b0110));

  assert_upo_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(user_out_o) |-> ($past(word_valid_i) && $past(op_i) == 4'b0010));

  assert_echo_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(echo_mode_o) |-> ($past(word_valid_i) && $past(op_i) == 4'b1110));

  assert_echo_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(echo_mode_o) |-> ($past(word_valid_i) && $past(op_i) == 4'b1010));

  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_valid_i) |-> ($stable(dac_code_o) && $stable(user_out_o) && $stable(echo_mode_o)));
endmodule

bind quad_dac_cmd_ctrl quad_dac_cmd_ctrl_checker i_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .op_i         (word_i[15:12]),
  .shdn_allow_i (shdn_allow_i),
  .dac_code_o   (dac_code_o),
  .shutdown_o   (shutdown_o),
  .out_en_o     (out_en_o),
  .user_out_o   (user_out_o),
  .echo_mode_o  (echo_mode_o)
);

// File: tb/test_quad_dac_cmd_ctrl.sv
`timescale 1ns/1ps
module test_quad_dac_cmd_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        shdn_allow_i = 1'b1;
  logic [39:0] dac_code_o;
  logic        shutdown_o, out_en_o, user_out_o, echo_mode_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  quad_dac_cmd_ctrl i_quad_dac_cmd_ctrl (
    .clk_i, .rst_ni, .word_valid_i, .word_i, .shdn_allow_i,
    .dac_code_o, .shutdown_o, .out_en_o, .user_out_o, .echo_mode_o
  );

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_codes(string req, logic [9:0] a, logic [9:0] b, logic [9:0] c, logic [9:0] d);
    chk(req, dac_code_o, {d, c, b, a});
  endtask

  // drive at negedge, accepted at posedge, checked at next negedge
  task automatic send(logic [3:0] op, logic [9:0] data, logic [1:0] sub);
    @(negedge clk_i);
    word_i = {op, data, sub};
    word_valid_i = 1'b1;
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_codes("R1 codes", 10'h0, 10'h0, 10'h0, 10'h0);
    chk("R1 shutdown", 40'(shutdown_o), 40'd0);
    chk("R1 out_en", 40'(out_en_o), 40'd1);
    chk("R1 upo", 40'(user_out_o), 40'd0);
    chk("R1 echo", 40'(echo_mode_o), 40'd0);
  endtask

  task automatic t_load_input;
    send(4'b0001, 10'h155, 2'b00);
    send(4'b0101, 10'h2AA, 2'b00);
    send(4'b1001, 10'h0F0, 2'b00);
    send(4'b1101, 10'h30F, 2'b00);
    chk_codes("R2 staging only", 10'h0, 10'h0, 10'h0, 10'h0);
    send(4'b0100, 10'h000, 2'b00);
    chk_codes("R4 transfer", 10'h155, 10'h2AA, 10'h0F0, 10'h30F);
  endtask

  task automatic t_load_xfer;
    send(4'b1011, 10'h3FF, 2'b00);
    chk_codes("R3 load and transfer", 10'h155, 10'h2AA, 10'h3FF, 10'h30F);
  endtask

  task automatic t_upo;
    send(4'b0110, 10'h000, 2'b00);
    chk("R7 upo high", 40'(user_out_o), 40'd1);
    send(4'b0010, 10'h3FF, 2'b00);
    chk("R7 upo low", 40'(user_out_o), 40'd0);
    chk_codes("R7 codes untouched", 10'h155, 10'h2AA, 10'h3FF, 10'h30F);
  endtask

  task automatic t_echo;
    send(4'b0001, 10'h011, 2'b00);
    send(4'b1110, 10'h000, 2'b00);
    chk("R8 echo rise", 40'(echo_mode_o), 40'd1);
    chk_codes("R8 transfer on 1110", 10'h011, 10'h2AA, 10'h3FF, 10'h30F);
    send(4'b0101, 10'h022, 2'b00);
    send(4'b1010, 10'h000, 2'b00);
    chk("R8 echo fall", 40'(echo_mode_o), 40'd0);
    chk_codes("R8 transfer on 1010", 10'h011, 10'h022, 10'h3FF, 10'h30F);
  endtask

  task automatic t_nop;
    send(4'b0000, 10'h3FF, 2'b11);
    chk_codes("R9 nop codes", 10'h011, 10'h022, 10'h3FF, 10'h30F);
    @(negedge clk_i);
    word_i = {4'b1000, 10'h000, 2'b00};
    word_valid_i = 1'b0;
    @(negedge clk_i);
    chk_codes("R9 invalid word", 10'h011, 10'h022, 10'h3FF, 10'h30F);
    chk("R9 upo", 40'(user_out_o), 40'd0);
    chk("R9 echo", 40'(echo_mode_o), 40'd0);
  endtask

  task automatic t_shutdown;
    @(negedge clk_i) shdn_allow_i = 1'b0;
    send(4'b1100, 10'h000, 2'b00);
    chk("R6 blocked sleep", 40'(shutdown_o), 40'd0);
    chk("R6 blocked out_en", 40'(out_en_o), 40'd1);
    shdn_allow_i = 1'b1;
    send(4'b1100, 10'h000, 2'b00);
    chk("R6 sleep", 40'(shutdown_o), 40'd1);
    chk("R6 out_en low", 40'(out_en_o), 40'd0);
    send(4'b0001, 10'h100, 2'b00);
    chk_codes("R11 held in sleep", 10'h011, 10'h022, 10'h3FF, 10'h30F);
    chk("R11 still asleep", 40'(shutdown_o), 40'd1);
    shdn_allow_i = 1'b0;
    @(negedge clk_i);
    chk("R10 lockout wake", 40'(shutdown_o), 40'd0);
    chk("R10 out_en back", 40'(out_en_o), 40'd1);
    chk_codes("R10 codes restored", 10'h011, 10'h022, 10'h3FF, 10'h30F);
    shdn_allow_i = 1'b1;
    send(4'b1100, 10'h000, 2'b00);
    chk("R6 sleep again", 40'(shutdown_o), 40'd1);
    send(4'b0100, 10'h000, 2'b00);
    chk("R4 wake", 40'(shutdown_o), 40'd0);
    chk_codes("R11 retained staging", 10'h100, 10'h022, 10'h3FF, 10'h30F);
  endtask

  task automatic t_broadcast;
    send(4'b1100, 10'h000, 2'b00);
    chk("R6 sleep before broadcast", 40'(shutdown_o), 40'd1);
    send(4'b1000, 10'h201, 2'b11);
    chk("R5 wake", 40'(shutdown_o), 40'd0);
    chk_codes("R5 broadcast", 10'h201, 10'h201, 10'h201, 10'h201);
    send(4'b0100, 10'h000, 2'b00);
    chk_codes("R5 staging also written", 10'h201, 10'h201, 10'h201, 10'h201);
  endtask

  task automatic t_sub_bits;
    send(4'b0011, 10'h3C3, 2'b11);
    chk_codes("R12 sub-bits ignored", 10'h3C3, 10'h201, 10'h201, 10'h201);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load_input();
    t_load_xfer();
    t_upo();
    t_echo();
    t_nop();
    t_shutdown();
    t_broadcast();
    t_sub_bits();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule